// File: doc/BRIEF.md
# Multi-Register Word Transfer Sequencer

This block moves a chosen group of the eight low registers between a register file and word-addressed memory, one word per cycle. A command carries an 8-bit selection mask, a mode, a base value and, for the two ascending forms, a 3-bit base register number. Four modes exist. The two ascending modes load or store from the base upward. Push walks downward from just below the stack pointer, and pop walks upward from the stack pointer. Push may also save the link register, and pop may also reload the program counter.

Each word goes through a request/ready port. The sequencer holds its request until ready is seen, then moves on to the next selected register. The register file is read through a combinational port for stores and written through a one-cycle write strobe for loads. When the last word has moved, the block gives a one-cycle done pulse. Alongside it come the value to write back to the base or stack pointer, a flag saying whether that writeback applies, the register it targets and the number of words moved.

Top module: `multireg_xfer`

## Requirements
- R1: After reset, busy, done, mem_req and rf_we are all low. Modes are encoded as 0 for ascending load, 1 for ascending store, 2 for push and 3 for pop.
- R2: Ascending load visits the set mask bits from bit 0 to bit 7, starting at base_val and adding 4 after each word. Each word read is written to register i (rf_wr_idx = i), with the data unchanged.
- R3: Ascending store visits the set bits in the same upward order, driving the value of register i (read through rf_rd_idx) onto mem_wdata. At done, wb_en is 1, wb_idx is base_idx and wb_data is the final address.
- R4: Ascending load raises wb_en at done only when mask bit base_idx is clear. In both cases wb_data is the final address and wb_idx is base_idx.
- R5: Push stores the selected registers from bit 7 down to bit 0, starting at base_val - 4 and subtracting 4 after each word. At done, wb_en is 1, wb_idx is 13 and wb_data is the lowest address written.
- R6: With add_extra set, push stores register 14 first, at base_val - 4, ahead of any masked register.
- R7: Pop loads the selected registers upward from base_val. At done, wb_en is 1, wb_idx is 13 and wb_data is the address after the last word read.
- R8: With add_extra set, pop reads one more word after the masked registers and writes it to register 15 with bit 0 cleared. This word counts as a transfer and advances the address by 4.
- R9: While mem_req is high and mem_ready is low, mem_addr, mem_we and mem_req hold. The sequence of accesses does not depend on how ready stalls.
- R10: done is high for exactly one cycle, in the cycle that follows the accepting edge of the last access. xfer_count then equals the number of words moved.
- R11: A command with an empty mask and no extra register makes no memory access. done rises in the cycle after the start edge, with xfer_count 0, wb_en 1 and wb_data equal to base_val.
- R12: start is ignored while busy is high. The running command's accesses are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a command when idle |
| mode | input | 2 | 0 load, 1 store, 2 push, 3 pop |
| reg_list | input | 8 | Register selection mask, bit i selects register i |
| base_idx | input | 3 | Base register number for the ascending modes |
| add_extra | input | 1 | Push: include register 14; pop: include register 15 |
| base_val | input | W | Base register or stack pointer value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | W | Word address |
| mem_wdata | output | W | Write data |
| mem_ready | input | 1 | Memory accepts the current access |
| mem_rdata | input | W | Read data, valid with mem_ready |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | W | Register file read data |
| rf_we | output | 1 | Register file write strobe |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | W | Register file write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Writeback applies, valid with done |
| wb_idx | output | 4 | Writeback register, valid with done |
| wb_data | output | W | Final base value, valid with done |
| xfer_count | output | 4 | Words moved, valid with done |

## Verification
Some properties are checked on every cycle. The address and direction hold while the sequencer stalls. The address moves by a word in the right direction after each accepted access. done is a single-cycle pulse and no request is active at that point. A load into register 15 is always followed at once by done, and a start during a run keeps the block busy. Several things can only be shown by the scenarios, which compare every access against an independently built list: the order in which the mask is scanned, that the link register goes first, the clearing of bit 0 on the program counter, the suppression of load writeback, the empty-command timing and the final values.

// File: rtl/multireg_xfer.sv
module multireg_xfer #(
  parameter int W      = 32,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [7:0]   reg_list,
  input  logic [2:0]   base_idx,
  input  logic         add_extra,
  input  logic [W-1:0] base_val,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ready,
  input  logic [W-1:0] mem_rdata,
  output logic [3:0]   rf_rd_idx,
  input  logic [W-1:0] rf_rd_data,
  output logic         rf_we,
  output logic [3:0]   rf_wr_idx,
  output logic [W-1:0] rf_wr_data,
  output logic         busy,
  output logic         done,
  output logic         wb_en,
  output logic [3:0]   wb_idx,
  output logic [W-1:0] wb_data,
  output logic [3:0]   xfer_count
);

  localparam logic [1:0] M_LOAD = 2'd0;
  localparam logic [1:0] M_PUSH = 2'd2;
  localparam logic [1:0] M_POP  = 2'd3;
  localparam logic [W-1:0] STEP = W'(4);

  logic         busy_q, done_q, extra_q, hit_q;
  logic [1:0]   mode_q;
  logic [7:0]   list_q;
  logic [2:0]   bidx_q;
  logic [W-1:0] addr_q;
  logic [3:0]   cnt_q;

  logic [2:0] lo_bit, hi_bit;
  always_comb begin
    lo_bit = 3'd0;
    hi_bit = 3'd0;
    for (int i = 7; i >= 0; i--) if (list_q[i]) lo_bit = 3'(i);
    for (int i = 0; i < 8; i++)  if (list_q[i]) hi_bit = 3'(i);
  end

  wire is_push   = (mode_q == M_PUSH);
  wire is_pop    = (mode_q == M_POP);
  wire is_load   = (mode_q == M_LOAD) || is_pop;
  wire extra_now = extra_q && (is_push || (is_pop && list_q == 8'd0));
  wire have      = (|list_q) || extra_q;
  wire fire      = busy_q && have && mem_ready;

  logic [3:0] cur_idx;
  assign cur_idx = extra_now ? (is_push ? 4'(LR_IDX) : 4'(PC_IDX))
                             : {1'b0, is_push ? hi_bit : lo_bit};

  wire [7:0]   list_nxt  = extra_now ? list_q : (list_q & ~(8'd1 << cur_idx[2:0]));
  wire         extra_nxt = extra_now ? 1'b0 : extra_q;
  wire [W-1:0] addr_nxt  = is_push ? addr_q - STEP : addr_q + STEP;
  wire         last      = (list_nxt == 8'd0) && !extra_nxt;
  wire         start_x   = add_extra && mode[1];

  assign busy       = busy_q;
  assign done       = done_q;
  assign mem_req    = busy_q && have;
  assign mem_we     = !is_load;
  assign mem_addr   = addr_q;
  assign mem_wdata  = rf_rd_data;
  assign rf_rd_idx  = cur_idx;
  assign rf_we      = fire && is_load;
  assign rf_wr_idx  = cur_idx;
  assign rf_wr_data = (cur_idx == 4'(PC_IDX)) ? {mem_rdata[W-1:1], 1'b0} : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      extra_q    <= 1'b0;
      hit_q      <= 1'b0;
      mode_q     <= M_LOAD;
      list_q     <= 8'd0;
      bidx_q     <= 3'd0;
      addr_q     <= '0;
      cnt_q      <= 4'd0;
      wb_en      <= 1'b0;
      wb_idx     <= 4'd0;
      wb_data    <= '0;
      xfer_count <= 4'd0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        mode_q  <= mode;
        list_q  <= reg_list;
        extra_q <= start_x;
        bidx_q  <= base_idx;
        hit_q   <= reg_list[base_idx];
        addr_q  <= (mode == M_PUSH) ? base_val - STEP : base_val;
        cnt_q   <= 4'd0;
        if (reg_list == 8'd0 && !start_x) begin
          done_q     <= 1'b1;
          wb_en      <= 1'b1;
          wb_idx     <= mode[1] ? 4'(SP_IDX) : {1'b0, base_idx};
          wb_data    <= base_val;
          xfer_count <= 4'd0;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (fire) begin
        list_q  <= list_nxt;
        extra_q <= extra_nxt;
        addr_q  <= addr_nxt;
        cnt_q   <= cnt_q + 4'd1;
        if (last) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          wb_en      <= !((mode_q == M_LOAD) && hit_q);
          wb_idx     <= mode_q[1] ? 4'(SP_IDX) : {1'b0, bidx_q};
          wb_data    <= is_push ? addr_q : addr_nxt;
          xfer_count <= cnt_q + 4'd1;
        end
      end
    end
  end

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !is_push) |=> (!mem_req || mem_addr == $past(mem_addr) + STEP));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && is_push) |=> (!mem_req || mem_addr == $past(mem_addr) - STEP));

  assert_pc_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_wr_idx == 4'(PC_IDX)) |=> done);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));

  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_ready) |=> (busy && $stable(mem_addr)));

endmodule

// File: tb/multireg_xfer_tb.sv
module multireg_xfer_tb;
  localparam int W = 32;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic         start = 0, add_extra = 0, mem_ready = 1;
  logic [1:0]   mode = 0;
  logic [7:0]   reg_list = 0;
  logic [2:0]   base_idx = 0;
  logic [W-1:0] base_val = 0;
  logic         mem_req, mem_we, rf_we, busy, done, wb_en;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data, wb_data;
  logic [3:0]   rf_rd_idx, rf_wr_idx, wb_idx, xfer_count;

  logic [W-1:0] mem [64];
  logic [W-1:0] rf [16];
  assign mem_rdata  = mem[mem_addr[7:2]];
  assign rf_rd_data = rf[rf_rd_idx];

  multireg_xfer #(.W(W)) u_dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, last_fire = 0, lc = 0;
  logic stall = 0;
  logic [W-1:0] log_addr [256];
  logic [W-1:0] log_data [256];
  logic [3:0]   log_idx  [256];
  logic         log_we   [256];

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      log_addr[lc[7:0]] <= mem_addr;
      log_we[lc[7:0]]   <= mem_we;
      log_idx[lc[7:0]]  <= mem_we ? rf_rd_idx : rf_wr_idx;
      log_data[lc[7:0]] <= mem_we ? mem_wdata : rf_wr_data;
      lc        <= lc + 1;
      last_fire <= cyc;
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end
    if (rf_we) rf[rf_wr_idx] <= rf_wr_data;
    cyc <= cyc + 1;
  end

  always @(negedge clk) mem_ready <= stall ? ~mem_ready : 1'b1;

  task automatic chk(input bit ok, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  int           e_n;
  logic [3:0]   e_idx  [16];
  logic [W-1:0] e_addr [16];
  logic         e_we   [16];
  logic [W-1:0] e_wb;

  task automatic add_exp(input logic [3:0] idx, input logic [W-1:0] a, input logic we);
    e_idx[e_n] = idx; e_addr[e_n] = a; e_we[e_n] = we; e_n++;
  endtask

  task automatic build(input logic [1:0] md, input logic ex, input logic [7:0] lst, input logic [W-1:0] b);
    logic [W-1:0] a;
    e_n = 0;
    if (md == 2'd2) begin
      a = b - 4;
      if (ex) begin add_exp(4'd14, a, 1'b1); a = a - 4; end
      for (int i = 7; i >= 0; i--) if (lst[i]) begin add_exp(4'(i), a, 1'b1); a = a - 4; end
      e_wb = a + 4;
    end else begin
      a = b;
      for (int i = 0; i < 8; i++) if (lst[i]) begin add_exp(4'(i), a, md == 2'd1); a = a + 4; end
      if (md == 2'd3 && ex) begin add_exp(4'd15, a, 1'b0); a = a + 4; end
      e_wb = a;
    end
  endtask

  task automatic run_op(input string tag, input logic [1:0] md, input logic ex, input logic [2:0] bi,
                        input logic [7:0] lst, input logic [W-1:0] b, input bit poke);
    int n, lc0;
    logic [W-1:0] ev;
    build(md, ex, lst, b);
    lc0 = lc;
    mode = md; add_extra = ex; base_idx = bi; reg_list = lst; base_val = b; start = 1;
    @(negedge clk);
    start = 0;
    n = 1;
    while (!done && n < 2000) begin
      if (poke && n == 2) begin start = 1; mode = 2'd1; reg_list = 8'hFF; base_val = 32'h0; end
      else start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    chk(done, {tag, " done seen"}, W'(done), 1);
    chk(lc - lc0 == e_n, {tag, " access count"}, W'(lc - lc0), W'(e_n));
    for (int k = 0; k < e_n && k < lc - lc0; k++) begin
      chk(log_addr[(lc0 + k) % 256] == e_addr[k], {tag, " addr"}, log_addr[(lc0 + k) % 256], e_addr[k]);
      chk(log_idx[(lc0 + k) % 256] == e_idx[k], {tag, " reg order"}, W'(log_idx[(lc0 + k) % 256]), W'(e_idx[k]));
      chk(log_we[(lc0 + k) % 256] == e_we[k], {tag, " direction"}, W'(log_we[(lc0 + k) % 256]), W'(e_we[k]));
      if (e_we[k]) ev = rf[e_idx[k]];
      else begin
        ev = mem[e_addr[k][7:2]];
        if (e_idx[k] == 4'd15) ev[0] = 1'b0;
      end
      chk(log_data[(lc0 + k) % 256] == ev, {tag, " data"}, log_data[(lc0 + k) % 256], ev);
    end
    chk(wb_data == e_wb, {tag, " wb_data"}, wb_data, e_wb);
    chk(wb_en == !(md == 2'd0 && lst[bi]), {tag, " wb_en"}, W'(wb_en), W'(!(md == 2'd0 && lst[bi])));
    chk(wb_idx == (md[1] ? 4'd13 : {1'b0, bi}), {tag, " wb_idx"}, W'(wb_idx), W'(md[1] ? 4'd13 : {1'b0, bi}));
    chk(xfer_count == 4'(e_n), {tag, " R10 xfer_count"}, W'(xfer_count), W'(e_n));
    if (e_n > 0) chk(cyc == last_fire + 1, {tag, " R10 done timing"}, W'(cyc), W'(last_fire + 1));
    else chk(n == 1, {tag, " R11 done one cycle after start"}, W'(n), 1);
    if (stall && e_n > 0) chk(n > e_n, {tag, " R9 stalled run longer"}, W'(n), W'(e_n));
    @(negedge clk);
    chk(!done && !busy && !mem_req, {tag, " R10 single pulse, idle"}, W'({done, busy, mem_req}), 0);
  endtask

  localparam logic [45:0] VEC [8] = '{
    {2'd0, 1'b0, 3'd0, 8'hA6, 32'h100},
    {2'd0, 1'b0, 3'd2, 8'h0C, 32'h080},
    {2'd1, 1'b0, 3'd3, 8'h91, 32'h040},
    {2'd2, 1'b1, 3'd0, 8'h41, 32'h0F0},
    {2'd2, 1'b0, 3'd0, 8'hFF, 32'h0C0},
    {2'd3, 1'b1, 3'd0, 8'h82, 32'h020},
    {2'd3, 1'b1, 3'd0, 8'h00, 32'h060},
    {2'd2, 1'b1, 3'd0, 8'h00, 32'h0A0}
  };
  localparam string VTAG [8] = '{"R2 load", "R4 load base in list", "R3 store", "R6 push with LR",
                                 "R5 push all", "R8 R7 pop with PC", "R8 pop PC only", "R6 push LR only"};

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'hC0DE_0001 + (k << 8);
    for (int k = 0; k < 16; k++) rf[k] = 32'h5500_0000 + k;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R1 reset state", W'({busy, done, mem_req, rf_we}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 idle after reset", W'({busy, done, mem_req}), 0);
    for (int v = 0; v < 8; v++)
      run_op(VTAG[v], VEC[v][45:44], VEC[v][43], VEC[v][42:40], VEC[v][39:32], VEC[v][31:0], 1'b0);
    run_op("R11 empty load", 2'd0, 1'b0, 3'd1, 8'h00, 32'h0AC, 1'b0);
    run_op("R11 empty push", 2'd2, 1'b0, 3'd0, 8'h00, 32'h0B0, 1'b0);
    run_op("R11 empty store ignores extra", 2'd1, 1'b1, 3'd0, 8'h00, 32'h034, 1'b0);
    stall = 1;
    run_op("R9 stalled load", 2'd0, 1'b0, 3'd7, 8'h3C, 32'h010, 1'b0);
    run_op("R9 stalled push", 2'd2, 1'b1, 3'd0, 8'h18, 32'h0E0, 1'b0);
    run_op("R12 start while busy", 2'd1, 1'b0, 3'd5, 8'h0F, 32'h0C0, 1'b1);
    stall = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule